// File: doc/BRIEF.md
# Password Protection Unlock Unit

This block guards a chip-level protection lock with a 64-bit password held as four 16-bit portions. Software talks to it through plain bus write and read cycles. Every operation starts with a fixed three-write key sequence that carries an operation code, and most operations then take one more bus cycle. The operations are: program a password portion, read the password back, present a portion for unlock, arm the mode lock, and read the mode-lock status.

To unlock, software issues the whole key sequence again for each portion and presents the portions in index order. The lock flag clears only when all four portions have matched, in order. Every portion after the first must arrive at least a set number of clock cycles after the previous one. A portion that does not match, arrives out of order or arrives too early throws away the progress made so far.

Arming the mode lock starts a programming delay. When the delay ends, the mode-lock flag sets for good. From then on, password readback returns all ones and password programming is refused.

Top module: `pw_unlock_unit`

## Requirements
- R1: After reset `pw_locked` is 1, `mode_locked` is 0, `bus_rdata` is 0 and all four stored portions are 16'hFFFF.
- R2: An operation starts with three writes: addr 12'h555 with data[7:0]=8'hAA, then addr 12'h2AA with data[7:0]=8'h55, then addr 12'h555 with data[7:0]=the op code. Any write that breaks this chain returns the decoder to idle, and the rest of the chain has no effect.
- R3: Op code 8'h38 (program) makes the next write store its 16-bit data into portion addr[1:0].
- R4: Op code 8'hC8 (verify) puts the unit in readback mode. Each read strobe then loads portion addr[1:0] into `bus_rdata` at the next clock edge. The mode lasts until the next write.
- R5: Op code 8'h28 (unlock) makes the next write present its data as portion addr[1:0]. `pw_locked` falls at the clock edge of the fourth matching in-order portion.
- R6: A portion whose value or index differs from the one expected resets the unlock progress to index 0.
- R7: A portion whose expected index is above 0 is accepted only if at least GAP_CYC clock edges separate its write edge from the previous portion write edge. An earlier portion counts as a failure under R6. Every portion write restarts the spacing count.
- R8: Op code 8'h68 (arm) makes the next write start a delay. `mode_locked` rises exactly PROG_CYC edges after that write edge.
- R9: Op code 8'h48 (status) makes each following read return `mode_locked` in bit 0 and zeros in all other bits. This mode also lasts until the next write.
- R10: While `mode_locked` is 1, verify reads return 16'hFFFF.
- R11: A program write is ignored when `mode_locked` is 1, and also when it falls on the edge where `mode_locked` sets.
- R12: Until the next reset, `pw_locked` never rises again and `mode_locked` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Bus address (low 12 bits decoded) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pw_locked | output | 1 | Protection lock, 1 = locked |
| mode_locked | output | 1 | Mode lock, 1 = password frozen and hidden |

## Verification
Two functions can act on the same clock edge. The first is the end of the mode-lock delay. The second is a password-program write, which the delay's completion must override. The bench counts edges from the arm write and places the program write's data cycle exactly on the completion edge. A second program write follows later. The judgement is then made at the ports: an unlock with the original password must still succeed, which shows that neither write took effect. A sweep of the spacing before the second portion also lands one trial exactly on the GAP_CYC boundary and one a single cycle short of it.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  OP_PW_PROG   = 8'h38;
  localparam logic [7:0]  OP_PW_VERIFY = 8'hC8;
  localparam logic [7:0]  OP_PW_UNLOCK = 8'h28;
  localparam logic [7:0]  OP_ML_ARM    = 8'h68;
  localparam logic [7:0]  OP_ML_STAT   = 8'h48;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_VERIFY, ST_UNLK, ST_ARM, ST_STAT
  } seq_st_t;

  // one step of the key chain
  function automatic logic key_hit(logic [11:0] a, logic [7:0] d,
                                   logic [11:0] ea, logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // op code to the state that waits for the operation's next bus cycle
  function automatic seq_st_t op_state(logic [7:0] op);
    case (op)
      OP_PW_PROG:   return ST_PROG;
      OP_PW_VERIFY: return ST_VERIFY;
      OP_PW_UNLOCK: return ST_UNLK;
      OP_ML_ARM:    return ST_ARM;
      OP_ML_STAT:   return ST_STAT;
      default:      return ST_IDLE;
    endcase
  endfunction

  // the first portion of an attempt has no spacing rule
  function automatic logic spacing_met(logic [31:0] elapsed, logic [31:0] need,
                                       logic first);
    return first || (elapsed >= need);
  endfunction
endpackage

// File: rtl/pwu_cmd_seq.sv
module pwu_cmd_seq
  import pwu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [11:0] a12,
  input  logic [7:0]  d8,
  output logic        prog_ev,
  output logic        unlk_ev,
  output logic        arm_ev,
  output logic        rd_verify,
  output logic        rd_stat
);
  seq_st_t st, st_nx;
  logic    k1, k2;

  assign k1 = key_hit(a12, d8, KEY_ADDR_A, KEY_DATA_A);
  assign k2 = key_hit(a12, d8, KEY_ADDR_B, KEY_DATA_B);

  always_comb begin
    st_nx = st;
    if (we) begin
      case (st)
        ST_KEY1: st_nx = k2 ? ST_KEY2 : ST_IDLE;
        ST_KEY2: st_nx = (a12 == KEY_ADDR_A) ? op_state(d8) : ST_IDLE;
        ST_PROG, ST_UNLK, ST_ARM: st_nx = ST_IDLE;
        default: st_nx = k1 ? ST_KEY1 : ST_IDLE;   // idle, verify, status
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign prog_ev   = we && (st == ST_PROG);
  assign unlk_ev   = we && (st == ST_UNLK);
  assign arm_ev    = we && (st == ST_ARM);
  assign rd_verify = (st == ST_VERIFY);
  assign rd_stat   = (st == ST_STAT);

  // R2: at most one operation fires per write
  a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_ev, unlk_ev, arm_ev}));
  // R2: any operation event returns the chain to idle
  a_r2_event_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ev || unlk_ev || arm_ev) |=> (st == ST_IDLE));
endmodule

// File: rtl/pwu_store.sv
module pwu_store #(
  parameter int PORTIONS = 4,
  parameter int DATA_W   = 16,
  localparam int IW      = $clog2(PORTIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_ev,
  input  logic              prog_block,
  input  logic [IW-1:0]     sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              blank,
  output logic [DATA_W-1:0] cmp_word,
  output logic [DATA_W-1:0] rd_word,
  output logic              prog_drop
);
  logic [DATA_W-1:0]          pw [PORTIONS];
  logic [PORTIONS*DATA_W-1:0] pw_flat;

  for (genvar g = 0; g < PORTIONS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pw[g] <= '1;
      else if (prog_ev && !prog_block && (sel == IW'(g)))
        pw[g] <= wdata;
    end
    assign pw_flat[g*DATA_W +: DATA_W] = pw[g];
  end

  assign cmp_word  = pw[sel];
  assign rd_word   = blank ? '1 : pw[sel];
  assign prog_drop = prog_ev && prog_block;

  // R11: a refused program write leaves every portion as it was
  a_r11_drop_keeps_pw: assert property (@(posedge clk) disable iff (!rst_n)
    prog_drop |=> $stable(pw_flat));
  // R3: an accepted program write lands in the selected portion
  a_r3_prog_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ev && !prog_block) |=> (pw[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/pwu_unlock_chk.sv
module pwu_unlock_chk
  import pwu_pkg::*;
#(
  parameter int PORTIONS = 4,
  parameter int DATA_W   = 16,
  parameter int GAP_CYC  = 200,
  localparam int IW      = $clog2(PORTIONS),
  localparam int GW      = $clog2(GAP_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlk_ev,
  input  logic [IW-1:0]     sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] stored,
  output logic              locked,
  output logic              accept_ev,
  output logic              fail_ev,
  output logic              open_ev
);
  logic [IW-1:0] exp_idx;
  logic [GW-1:0] gap_cnt;
  logic          timing_ok;

  assign timing_ok = spacing_met(32'(gap_cnt), 32'(GAP_CYC), exp_idx == '0);
  assign accept_ev = unlk_ev && timing_ok && (sel == exp_idx) && (wdata == stored);
  assign fail_ev   = unlk_ev && !accept_ev;
  assign open_ev   = accept_ev && (exp_idx == IW'(PORTIONS - 1));

  // spacing count: edges since the last portion write, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_cnt <= GW'(GAP_CYC);
    else if (unlk_ev)                  gap_cnt <= GW'(1);
    else if (gap_cnt < GW'(GAP_CYC))   gap_cnt <= gap_cnt + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_idx <= '0;
      locked  <= 1'b1;
    end else begin
      if (fail_ev || open_ev) exp_idx <= '0;
      else if (accept_ev)     exp_idx <= exp_idx + IW'(1);
      if (open_ev)            locked  <= 1'b0;
    end
  end

  // R5: the lock only falls after a fourth in-order match
  a_r5_fall_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(unlk_ev && exp_idx == IW'(PORTIONS - 1)));
  // R6: a failed portion discards progress
  a_r6_fail_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev |=> (exp_idx == '0));
  // R12: the lock never re-arms
  a_r12_lock_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(locked));
endmodule

// File: rtl/pwu_mlock_timer.sv
module pwu_mlock_timer #(
  parameter int PROG_CYC = 10000,
  localparam int TW      = $clog2(PROG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_ev,
  output logic mode_lock,
  output logic busy,
  output logic done
);
  logic [TW-1:0] cnt;

  assign done = busy && (cnt == TW'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      mode_lock <= 1'b0;
    end else if (busy) begin
      if (done) begin
        busy      <= 1'b0;
        mode_lock <= 1'b1;
      end else begin
        cnt <= cnt + TW'(1);
      end
    end else if (arm_ev && !mode_lock) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  // R8: the mode lock sets only at the end of a delay
  a_r8_set_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_lock) |-> $past(busy));
  // R12: the mode lock is sticky
  a_r12_mlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(mode_lock));
endmodule

// File: rtl/pw_unlock_unit.sv
module pw_unlock_unit #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int PORTIONS = 4,
  parameter int GAP_CYC  = 200,
  parameter int PROG_CYC = 10000,
  localparam int IW      = $clog2(PORTIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pw_locked,
  output logic              mode_locked
);
  // named internal events
  logic              prog_ev, unlk_ev, arm_ev, rd_verify, rd_stat;
  logic              ml_busy, ml_done, prog_drop;
  logic              accept_ev, fail_ev, open_ev;
  logic [DATA_W-1:0] cmp_word, rd_word;

  pwu_cmd_seq i_seq (
    .clk(clk), .rst_n(rst_n), .we(bus_we),
    .a12(bus_addr[11:0]), .d8(bus_wdata[7:0]),
    .prog_ev(prog_ev), .unlk_ev(unlk_ev), .arm_ev(arm_ev),
    .rd_verify(rd_verify), .rd_stat(rd_stat)
  );

  pwu_mlock_timer #(.PROG_CYC(PROG_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .arm_ev(arm_ev),
    .mode_lock(mode_locked), .busy(ml_busy), .done(ml_done)
  );

  pwu_store #(.PORTIONS(PORTIONS), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rst_n(rst_n), .prog_ev(prog_ev),
    .prog_block(mode_locked || ml_done),
    .sel(bus_addr[IW-1:0]), .wdata(bus_wdata), .blank(mode_locked),
    .cmp_word(cmp_word), .rd_word(rd_word), .prog_drop(prog_drop)
  );

  pwu_unlock_chk #(.PORTIONS(PORTIONS), .DATA_W(DATA_W), .GAP_CYC(GAP_CYC)) i_chk (
    .clk(clk), .rst_n(rst_n), .unlk_ev(unlk_ev),
    .sel(bus_addr[IW-1:0]), .wdata(bus_wdata), .stored(cmp_word),
    .locked(pw_locked), .accept_ev(accept_ev), .fail_ev(fail_ev), .open_ev(open_ev)
  );

  // registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_re) begin
      if (rd_verify)    bus_rdata <= rd_word;
      else if (rd_stat) bus_rdata <= {{(DATA_W-1){1'b0}}, mode_locked};
      else              bus_rdata <= '0;
    end
  end

  // R10: a hidden password reads as all ones
  a_r10_blank_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && rd_verify && mode_locked) |=> (bus_rdata == '1));
  // R9: status reads carry only bit 0
  a_r9_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && rd_stat) |=> (bus_rdata[DATA_W-1:1] == '0));
  // R11: a program write on the completion edge is refused
  a_r11_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ev && ml_done) |-> prog_drop);
  // R5: opening needs an accepted portion, never a failed one
  a_r5_open_is_accept: assert property (@(posedge clk) disable iff (!rst_n)
    open_ev |-> (accept_ev && !fail_ev));
  // R8: arming while busy does not restart the delay
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ml_busy && !ml_done) |=> ml_busy);
endmodule

// File: tb/test_pw_unlock_unit.sv
module test_pw_unlock_unit;
  localparam int CLK_PERIOD = 10;
  localparam int GAP  = 12;
  localparam int PROG = 40;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        locked, mlock;

  int vectors = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  // bench model
  logic [15:0] m_pw [4];
  logic        m_locked;
  int          m_idx, last_pe;

  pw_unlock_unit #(.GAP_CYC(GAP), .PROG_CYC(PROG)) i_pw_unlock_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdata), .pw_locked(locked), .mode_locked(mlock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (!finished && cyc > WATCHDOG) begin
    errors++;
    $display("FAIL watchdog act=%0d exp=<%0d", cyc, WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] v);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic cmd(logic [7:0] op);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, {8'h00, op});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(1);
    for (int i = 0; i < 4; i++) m_pw[i] = 16'hFFFF;
    m_locked = 1'b1; m_idx = 0; last_pe = -100000;
  endtask

  // one full unlock sequence for one portion; model follows R5-R7
  task automatic portion(int idx, logic [15:0] val);
    bit ok;
    cmd(8'h28); wr(12'(idx), val);
    ok = (idx == m_idx) && (m_idx == 0 || cyc - last_pe >= GAP) && (val == m_pw[idx]);
    last_pe = cyc;
    if (ok) begin
      if (m_idx == 3) begin m_locked = 1'b0; m_idx = 0; end
      else m_idx++;
    end else m_idx = 0;
  endtask

  task automatic full_unlock(logic [15:0] bad_mask [4]);
    for (int i = 0; i < 4; i++) begin
      idle(GAP); portion(i, m_pw[i] ^ bad_mask[i]);
    end
  endtask

  task automatic verify_all(string req, bit hidden);
    logic [15:0] v;
    cmd(8'hC8);
    for (int i = 0; i < 4; i++) begin
      rd(12'(i), v);
      check(req, v, hidden ? 16'hFFFF : m_pw[i]);
    end
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] nomask [4];
    int g;
    for (int i = 0; i < 4; i++) nomask[i] = '0;
    do_reset();

    // R1: reset state
    check("R1 locked", {15'b0, locked}, 16'h0001);
    check("R1 mode_locked", {15'b0, mlock}, 16'h0000);
    check("R1 rdata", rdata, 16'h0000);
    verify_all("R1/R4 erased readback", 1'b0);

    // R7: spacing sweep around GAP for the second portion
    for (int d = 0; d <= 8; d++) begin
      do_reset();
      portion(0, 16'hFFFF); idle(d); portion(1, 16'hFFFF);
      idle(GAP); portion(2, 16'hFFFF); idle(GAP); portion(3, 16'hFFFF);
      check($sformatf("R7 spacing %0d", 8 + d), {15'b0, locked}, {15'b0, m_locked});
    end

    // R6: one wrong portion at each position keeps the lock
    for (int k = 0; k < 4; k++) begin
      logic [15:0] mask [4];
      do_reset();
      for (int i = 0; i < 4; i++) mask[i] = (i == k) ? 16'h0100 << k : 16'h0;
      full_unlock(mask);
      check($sformatf("R6 bad portion %0d", k), {15'b0, locked}, 16'h0001);
    end

    // R3/R4: program all four portions, read them back
    do_reset();
    for (int i = 0; i < 4; i++) begin
      m_pw[i] = 16'hA5C3 ^ 16'(i * 16'h1111);
      cmd(8'h38); wr(12'(i), m_pw[i]);
    end
    verify_all("R3/R4 programmed readback", 1'b0);

    // R2: broken key chains have no effect
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0054); wr(12'h555, 16'h0038); wr(12'h000, 16'h1234);
    wr(12'h555, 16'h00AA); wr(12'h000, 16'h00F0); wr(12'h2AA, 16'h0055);
    wr(12'h555, 16'h0038); wr(12'h001, 16'h1234);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h554, 16'h0038); wr(12'h002, 16'h1234);
    verify_all("R2 broken chain", 1'b0);

    // R6: out-of-order portions
    idle(GAP); portion(0, m_pw[0]); idle(GAP); portion(2, m_pw[2]);
    idle(GAP); portion(3, m_pw[3]);
    check("R6 out of order", {15'b0, locked}, 16'h0001);

    // R8/R11: arm, then a program write on the completion edge
    cmd(8'h68); wr(12'h000, 16'h0000); g = cyc;
    cmd(8'h48); rd(12'h000, v);
    check("R8 status during delay", v, 16'h0000);
    while (cyc + 8 < g + PROG) @(negedge clk);
    check("R8 not yet set", {15'b0, mlock}, 16'h0000);
    cmd(8'h38); wr(12'h000, ~m_pw[0]);
    check("R8 set after PROG_CYC", {15'b0, mlock}, 16'h0001);
    cmd(8'h38); wr(12'h001, 16'h0000);
    cmd(8'h48); rd(12'h000, v);
    check("R9 status set", v, 16'h0001);
    verify_all("R10 hidden readback", 1'b1);

    // R5/R11: original password still opens
    full_unlock(nomask);
    check("R5/R11 unlock with original", {15'b0, locked}, 16'h0000);

    // R12: no re-lock, mode lock sticky
    cmd(8'h68); wr(12'h000, 16'h0000);
    full_unlock('{16'h1, 16'h1, 16'h1, 16'h1});
    idle(PROG + 2);
    check("R12 lock stays open", {15'b0, locked}, 16'h0000);
    check("R12 mode lock stays", {15'b0, mlock}, 16'h0001);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule